// File: doc/BRIEF.md
# Four-Pin Port with Direction Register

This block is a small general-purpose I/O port with four pins. Pins 0 to 2 are bidirectional and pin 3 can only be read. A CPU-style register bus reaches two registers: a data register, whose writes set an output latch and whose reads return the synchronized pin levels, and a direction register, where a 1 makes a pin an input. Each pin has an analog-select input from outside the block. A pin that is analog-selected is never driven, and it reads back as 0.

The direction register also holds a parallel-mode bit and three read-only status bits that belong to a neighbouring function. When parallel mode is set, pins 0 to 2 are handed to that external control function. Their drivers are switched off, and their synchronized levels are presented on a dedicated control output. Pad electronics, input buffer types and the analog converter itself are outside the block.

Top module: `quad_port`

## Requirements
- R1: Pin 3 is input-only. `pin_oe[3]` and `pin_out[3]` are always 0. Direction bit 3 ignores writes and always reads back as 1.
- R2: `reg_addr` selects the register: 0 is the data register and 1 is the direction register. A direction read returns `{stat_in[2:0], par_mode, dir[3:0]}`. Bits 4 and 2:0 are writable, and bits 7:5 follow `stat_in` and ignore writes.
- R3: For pins 0 to 2, an asserted `ana_sel[i]` forces data-read bit i to 0 and holds `pin_oe[i]` at 0. Pin 3 has no analog mode, so `ana_sel[3]` has no effect.
- R4: After reset, direction bits 4:0 read 0_1111, the output latch is 000, and every `pin_oe` bit is 0.
- R5: A data read returns 0 in bits 7:4 and the pin levels in bits 3:0 after a two-flop synchronizer. A change on `pin_in` shows up in a read after the second rising clock edge, not after the first.
- R6: A data write updates the output latch whatever the pin direction, and `pin_out[2:0]` shows the latch from the next cycle on. Once the direction bit is cleared, the latched value is driven.
- R7: For i in 0..2, `pin_oe[i]` is 1 exactly when direction bit i is 0, `ana_sel[i]` is 0 and parallel mode is off.
- R8: With parallel mode set, `pin_oe[2:0]` is 0 and `par_ctrl` equals the synchronized levels of pins 2:0. With parallel mode clear, `par_ctrl` reads 3'b111 (idle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 data, 1 direction |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| pin_in | input | 4 | Pin levels from the pads |
| pin_out | output | 4 | Output latch towards the pads |
| pin_oe | output | 4 | Per-pin driver enable |
| ana_sel | input | 4 | Per-pin analog select |
| stat_in | input | 3 | Status bits of the neighbouring function |
| par_mode | output | 1 | Parallel mode bit |
| par_ctrl | output | 3 | Synchronized control inputs in parallel mode |

## Verification
On every cycle, the assertions check the following:
- pin 3 is never driven;
- direction bit 3 reads as 1;
- analog-selected pins read 0, and the upper bits of a data read are 0;
- a data write shows up on `pin_out` one cycle later;
- parallel mode keeps pins 0 to 2 undriven;
- reset leaves every driver off.

Only the bench scenarios can show the full output-enable truth table over mixed direction and analog patterns. The same holds for the two-edge synchronizer latency, a latch that is written while the pin is an input and then driven, and the idle value of the control output.

// File: rtl/port_pkg.sv
package port_pkg;
   typedef enum logic {
      SEL_DATA = 1'b0,
      SEL_DIR  = 1'b1
   } port_reg_e;
endpackage

// File: rtl/port_sync.sv
module port_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs
   import port_pkg::*;
#(
   parameter int                  NUM_PINS        = 4,
   parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 4'b1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  port_reg_e           wr_sel,
   input  logic [NUM_PINS:0]   wr_data,
   output logic [NUM_PINS-1:0] out_latch,
   output logic [NUM_PINS-1:0] dir_q,
   output logic                par_q
);
   logic wr_dat;
   logic wr_dir;

   assign wr_dat = wr_en && (wr_sel == SEL_DATA);
   assign wr_dir = wr_en && (wr_sel == SEL_DIR);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_latch[i] <= 1'b0;
            dir_q[i]     <= 1'b1;
         end else begin
            if (wr_dat) out_latch[i] <= wr_data[i] & ~INPUT_ONLY_MASK[i];
            if (wr_dir) dir_q[i]     <= wr_data[i] |  INPUT_ONLY_MASK[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      par_q <= 1'b0;
      else if (wr_dir) par_q <= wr_data[NUM_PINS];
   end
endmodule

// File: rtl/port_drive.sv
module port_drive #(
   parameter int                  NUM_PINS        = 4,
   parameter int                  PAR_PINS        = 3,
   parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 4'b1000,
   parameter logic [NUM_PINS-1:0] ANALOG_MASK     = 4'b0111
) (
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic                par_q,
   input  logic [NUM_PINS-1:0] ana_sel,
   input  logic [NUM_PINS-1:0] out_latch,
   input  logic [NUM_PINS-1:0] pin_sync,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] rd_pins,
   output logic [PAR_PINS-1:0] par_ctrl
);
   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic ana_eff;
      logic par_owned;
      assign ana_eff   = ANALOG_MASK[i] & ana_sel[i];
      assign par_owned = (i < PAR_PINS) ? par_q : 1'b0;
      if (INPUT_ONLY_MASK[i]) begin : g_in_only
         assign pin_oe[i]  = 1'b0;
         assign pin_out[i] = 1'b0;
      end else begin : g_bidir
         assign pin_oe[i]  = ~dir_q[i] & ~ana_eff & ~par_owned;
         assign pin_out[i] = out_latch[i];
      end
      assign rd_pins[i] = pin_sync[i] & ~ana_eff;
   end

   for (genvar j = 0; j < PAR_PINS; j++) begin : g_par
      assign par_ctrl[j] = par_q ? pin_sync[j] : 1'b1;
   end
endmodule

// File: rtl/quad_port.sv
module quad_port
   import port_pkg::*;
#(
   parameter int                  NUM_PINS        = 4,
   parameter int                  REG_W           = 8,
   parameter int                  PAR_PINS        = 3,
   parameter int                  SYNC_STAGES     = 2,
   parameter logic [NUM_PINS-1:0] INPUT_ONLY_MASK = 4'b1000,
   parameter logic [NUM_PINS-1:0] ANALOG_MASK     = 4'b0111,
   localparam int                 STAT_W          = REG_W - NUM_PINS - 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_addr,
   input  logic                reg_wr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   input  logic [NUM_PINS-1:0] ana_sel,
   input  logic [STAT_W-1:0]   stat_in,
   output logic                par_mode,
   output logic [PAR_PINS-1:0] par_ctrl
);
   if (STAT_W < 1)             begin : g_bad_w    $error("REG_W too small for NUM_PINS"); end
   if (SYNC_STAGES < 1)        begin : g_bad_sync $error("SYNC_STAGES must be >= 1");     end
   if (PAR_PINS > NUM_PINS)    begin : g_bad_par  $error("PAR_PINS exceeds NUM_PINS");    end
   if ((INPUT_ONLY_MASK & ANALOG_MASK) != '0) begin : g_bad_mask
      $error("an input-only pin cannot be analog-capable");
   end

   logic [NUM_PINS-1:0] out_latch;
   logic [NUM_PINS-1:0] dir_q;
   logic                par_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] rd_pins;
   port_reg_e           sel;
   logic                unused_wbits;

   assign sel          = port_reg_e'(reg_addr);
   assign unused_wbits = ^reg_wdata[REG_W-1:NUM_PINS+1];

   port_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin_in),
      .q    (pin_sync)
   );

   port_regs #(.NUM_PINS(NUM_PINS), .INPUT_ONLY_MASK(INPUT_ONLY_MASK)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .wr_sel   (sel),
      .wr_data  (reg_wdata[NUM_PINS:0]),
      .out_latch(out_latch),
      .dir_q    (dir_q),
      .par_q    (par_q)
   );

   port_drive #(
      .NUM_PINS       (NUM_PINS),
      .PAR_PINS       (PAR_PINS),
      .INPUT_ONLY_MASK(INPUT_ONLY_MASK),
      .ANALOG_MASK    (ANALOG_MASK)
   ) u_drive (
      .dir_q    (dir_q),
      .par_q    (par_q),
      .ana_sel  (ana_sel),
      .out_latch(out_latch),
      .pin_sync (pin_sync),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe),
      .rd_pins  (rd_pins),
      .par_ctrl (par_ctrl)
   );

   always_comb begin
      unique case (sel)
         SEL_DATA: reg_rdata = {{(REG_W-NUM_PINS){1'b0}}, rd_pins};
         SEL_DIR:  reg_rdata = {stat_in, par_q, dir_q};
         default:  reg_rdata = '0;
      endcase
   end

   assign par_mode = par_q;
endmodule

// File: rtl/quad_port_checker.sv
module quad_port_checker #(
   parameter int                  NUM_PINS    = 4,
   parameter int                  REG_W       = 8,
   parameter int                  PAR_PINS    = 3,
   parameter logic [NUM_PINS-1:0] ANALOG_MASK = 4'b0111
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_addr,
   input logic                reg_wr,
   input logic [REG_W-1:0]    reg_wdata,
   input logic [REG_W-1:0]    reg_rdata,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] ana_sel,
   input logic                par_mode
);
   assert_pin3_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_oe[NUM_PINS-1] && !pin_out[NUM_PINS-1]));

   assert_dir3_reads_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr |-> reg_rdata[NUM_PINS-1]);

   assert_analog_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_addr |-> ((reg_rdata[NUM_PINS-1:0] & ana_sel & ANALOG_MASK) == '0));

   assert_data_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_addr |-> (reg_rdata[REG_W-1:NUM_PINS] == '0));

   assert_latch_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_addr) |=> (pin_out[NUM_PINS-2:0] == $past(reg_wdata[NUM_PINS-2:0])));

   assert_par_mode_undriven_R8: assert property (@(posedge clk) disable iff (!rst_n)
      par_mode |-> (pin_oe[PAR_PINS-1:0] == '0));

   assert_reset_drivers_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && !par_mode));
endmodule

bind quad_port quad_port_checker #(
   .NUM_PINS   (NUM_PINS),
   .REG_W      (REG_W),
   .PAR_PINS   (PAR_PINS),
   .ANALOG_MASK(ANALOG_MASK)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_addr (reg_addr),
   .reg_wr   (reg_wr),
   .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .ana_sel  (ana_sel),
   .par_mode (par_mode)
);

// File: tb/quad_port_test.sv
module quad_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_addr = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [3:0] pin_in = 4'hF;
   logic [3:0] pin_out;
   logic [3:0] pin_oe;
   logic [3:0] ana_sel = 4'b0111;
   logic [2:0] stat_in = 3'b101;
   logic       par_mode;
   logic [2:0] par_ctrl;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   quad_port uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .ana_sel(ana_sel),
      .stat_in(stat_in), .par_mode(par_mode), .par_ctrl(par_ctrl)
   );

   // {dir[3:0], ana_sel[3:0], data[3:0], expected pin_oe[3:0]}
   localparam logic [15:0] VEC [6] = '{
      16'h00A7, 16'hF050, 16'h5032, 16'h0166, 16'h08F7, 16'hA491
   };

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R4 reset state
      check("R4 oe", {4'h0, pin_oe}, 8'h00);
      check("R4 out", {4'h0, pin_out}, 8'h00);
      rd(1'b1, r); check("R4 dir", r, 8'hAF);
      rd(1'b0, r); check("R3 R5 reset data", r, 8'h08);
      check("R8 idle", {5'h0, par_ctrl}, 8'h07);

      // R1 R2 direction bit 3 sticks at 1; status ignores writes
      wr(1'b1, 8'h40);
      rd(1'b1, r); check("R1 R2 dir", r, 8'hA8);

      // R7 table of direction/analog/data patterns
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         ana_sel = VEC[k][11:8];
         wr(1'b1, {4'h0, VEC[k][15:12]});
         wr(1'b0, {4'hF, VEC[k][7:4]});
         #1;
         check($sformatf("R7 oe vec%0d", k), {4'h0, pin_oe}, {4'h0, VEC[k][3:0]});
         check($sformatf("R6 out vec%0d", k), {4'h0, pin_out}, {5'h0, VEC[k][6:4]});
      end

      // R6 latch written while input, then driven
      ana_sel = 4'b0000;
      wr(1'b1, 8'h0F);
      wr(1'b0, 8'h05);
      #1 check("R6 latch as input oe", {4'h0, pin_oe}, 8'h00);
      check("R6 latch as input out", {4'h0, pin_out}, 8'h05);
      wr(1'b1, 8'h00);
      #1 check("R6 driven oe", {4'h0, pin_oe}, 8'h07);
      check("R6 driven out", {4'h0, pin_out}, 8'h05);

      // R5 synchronizer latency
      pin_in = 4'h0;
      repeat (3) @(negedge clk);
      pin_in = 4'h6;
      @(negedge clk);
      rd(1'b0, r); check("R5 one edge", r, 8'h00);
      @(negedge clk);
      rd(1'b0, r); check("R5 two edges", r, 8'h06);

      // R3 analog masking, pin 3 not analog-capable
      ana_sel = 4'b0010;
      rd(1'b0, r); check("R3 mask pin1", r, 8'h04);
      pin_in = 4'hF;
      ana_sel = 4'b1000;
      repeat (3) @(negedge clk);
      rd(1'b0, r); check("R3 pin3 no analog", r, 8'h0F);
      ana_sel = 4'b0000;
      pin_in = 4'h6;
      repeat (3) @(negedge clk);

      // R8 parallel mode
      wr(1'b1, 8'h10);
      #1 check("R8 mode", {7'h0, par_mode}, 8'h01);
      check("R8 oe off", {4'h0, pin_oe}, 8'h00);
      check("R8 ctrl", {5'h0, par_ctrl}, 8'h06);
      wr(1'b1, 8'h00);
      #1 check("R8 ctrl idle", {5'h0, par_ctrl}, 8'h07);
      check("R8 oe back", {4'h0, pin_oe}, 8'h07);

      // R2 status bits follow input
      stat_in = 3'b010;
      rd(1'b1, r); check("R2 status", r, 8'h48);

      done = 1;
      finish_run();
   end
endmodule